// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Sync and Alarm Responder

This block sits in the receive-side control of an E1 framer. It follows the alignment state
of the incoming line. There are three states: no alignment, basic (double-frame) alignment
with a CRC-4 multiframe search running, and full multiframe alignment. From that state it
drives two kinds of outgoing overhead: the remote alarm bit, and the two E-bits that report
received CRC-4 errors back to the far end.

The multiframe search has a time limit of 8 ms. The block counts 64 received frame starts,
which is four 16-frame multiframes. If no multiframe alignment turns up within that count,
it asks the bit-level aligner to restart the double-frame search.

The remote alarm follows loss of frame alignment and clears once basic framing is back. The
E-bits carry the CRC result of each received submultiframe into the next outgoing
multiframe. Without multiframe alignment they are held at a configured level. CRC
calculation and the bit-level alignment search are done by neighbouring blocks.

Top module: `e1_crc4_sync_resp`

## Requirements
- R1: After reset, `search_restart_o` is 0, `tx_a_bit_o` is 1 and the block is in the unaligned state.
- R2: In the multiframe-search state, `search_restart_o` goes high for exactly one cycle, in the cycle after the 64th `frame_tick_i` counted since the search began, provided no `mf_found_i` arrived first.
- R3: The frame counter is cleared on every restart request, so while the search continues a further request follows every 64 frame ticks.
- R4: `mf_found_i` during the search moves the block to multiframe alignment. After that, frame ticks raise no restart request.
- R5: While `align_lost_i` is high, `tx_a_bit_o` is 1 from the following cycle on, and the block returns to the unaligned state.
- R6: `tx_a_bit_o` falls to 0 in the cycle after `basic_aligned_i` is high with `align_lost_i` low. Otherwise it holds its value.
- R7: In multiframe alignment, `tx_ebits_o[0]` (Si bit of frame 13) reports submultiframe I and `tx_ebits_o[1]` (Si bit of frame 15) reports submultiframe II. A value of 0 means a CRC-4 error and 1 means no error. A result strobed by `smf_checked_i[k]` together with `smf_crc_bad_i[k]` is held pending and appears on the output after the next `tx_mf_tick_i`. A slot with no check in that interval reports 1. On entry to alignment both bits are 1.
- R8: Outside multiframe alignment, both bits of `tx_ebits_o` equal `async_ebit_i`, whatever the CRC inputs do.
- R9: Frame ticks seen in the unaligned or aligned states do not advance the search counter. Each entry to the search state starts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| basic_aligned_i | input | 1 | Double-frame alignment present |
| align_lost_i | input | 1 | Loss of frame alignment indication |
| mf_found_i | input | 1 | Strobe: CRC-4 multiframe alignment found |
| frame_tick_i | input | 1 | Strobe: one per received 125 us frame |
| tx_mf_tick_i | input | 1 | Strobe: start of the next outgoing multiframe |
| smf_checked_i | input | 2 | Strobe per submultiframe: CRC-4 check completed |
| smf_crc_bad_i | input | 2 | CRC-4 mismatch flag, valid with `smf_checked_i` |
| async_ebit_i | input | 1 | E-bit level driven while not multiframe aligned |
| search_restart_o | output | 1 | One-cycle request to restart the double-frame search |
| tx_a_bit_o | output | 1 | Outgoing remote alarm (A) bit |
| tx_ebits_o | output | 2 | Outgoing E-bits, [0] for frame 13, [1] for frame 15 |

## Verification
The bench aims at three sets of edges.

The first is the timeout. It looks for off-by-one errors at tick 63 versus tick 64, and for
a counter that is not cleared. A wrong design would raise the restart one frame early or
late, or only once.

The second is the meeting of a restart with a loss of alignment or a found multiframe. A
design that got this wrong would keep counting through lost alignment, or would raise a
restart after sync was reached.

The third is the E-bit path. A wrong design would swap the two submultiframe slots, invert
the error polarity, or leak stale errors into a multiframe with no checks. It would also
leak CRC activity onto the bits while unaligned, or ignore the asynchronous level setting.

// File: rtl/e1sr_pkg.sv
package e1sr_pkg;
    typedef enum logic [1:0] {
        ALIGN_NONE  = 2'd0,
        ALIGN_BASIC = 2'd1,
        ALIGN_MULTI = 2'd2
    } align_e;
endpackage

// File: rtl/e1sr_align.sv
module e1sr_align
    import e1sr_pkg::*;
#(
    parameter int FRAMES_PER_MF = 16,
    parameter int SEARCH_MFS    = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   basic_aligned_i,
    input  logic   align_lost_i,
    input  logic   mf_found_i,
    input  logic   frame_tick_i,
    output align_e state_o,
    output logic   restart_o
);
    localparam int LIMIT = FRAMES_PER_MF * SEARCH_MFS;
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        align_e        state;
        logic [CW-1:0] cnt;
        logic          restart;
    } align_t;

    align_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.restart = 1'b0;
        if (align_lost_i) begin
            s_d.state = ALIGN_NONE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.state)
                ALIGN_NONE: begin
                    if (basic_aligned_i) begin
                        s_d.state = ALIGN_BASIC;
                        s_d.cnt   = '0;
                    end
                end
                ALIGN_BASIC: begin
                    if (mf_found_i) begin
                        s_d.state = ALIGN_MULTI;
                        s_d.cnt   = '0;
                    end else if (frame_tick_i) begin
                        if (s_q.cnt == LAST) begin
                            s_d.restart = 1'b1;
                            s_d.cnt     = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                ALIGN_MULTI: s_d.cnt = '0;
                default: begin
                    s_d.state = ALIGN_NONE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ALIGN_NONE;
            s_q.cnt     <= '0;
            s_q.restart <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o   = s_q.state;
    assign restart_o = s_q.restart;

    // R2
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);
    // R2
    restart_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(frame_tick_i) && $past(s_q.state) == ALIGN_BASIC);
    // R5
    lost_to_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_lost_i |=> state_o == ALIGN_NONE && !restart_o);
    // R4
    multi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ALIGN_MULTI |=> !restart_o);
endmodule

// File: rtl/e1sr_rai.sv
module e1sr_rai (
    input  logic clk,
    input  logic rst_n,
    input  logic basic_aligned_i,
    input  logic align_lost_i,
    output logic rai_o
);
    typedef struct packed {
        logic rai;
    } rai_t;

    rai_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (align_lost_i)
            r_d.rai = 1'b1;
        else if (basic_aligned_i)
            r_d.rai = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.rai <= 1'b1;
        else        r_q <= r_d;
    end

    assign rai_o = r_q.rai;

    // R5
    rai_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_lost_i |=> rai_o);
    // R6
    rai_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_aligned_i && !align_lost_i) |=> !rai_o);
    // R6
    rai_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!basic_aligned_i && !align_lost_i) |=> $stable(rai_o));
endmodule

// File: rtl/e1sr_ebit.sv
module e1sr_ebit #(
    parameter int N_SMF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             tx_mf_tick_i,
    input  logic [N_SMF-1:0] smf_checked_i,
    input  logic [N_SMF-1:0] smf_crc_bad_i,
    input  logic             async_ebit_i,
    output logic [N_SMF-1:0] ebits_o
);
    typedef struct packed {
        logic [N_SMF-1:0] pend;
        logic [N_SMF-1:0] rep;
    } eb_t;

    eb_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (!sync_i) begin
            e_d.pend = '1;
            e_d.rep  = '1;
        end else begin
            if (tx_mf_tick_i) begin
                e_d.rep  = e_q.pend;
                e_d.pend = '1;
            end
            for (int k = 0; k < N_SMF; k++) begin
                if (smf_checked_i[k]) e_d.pend[k] = ~smf_crc_bad_i[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.pend <= '1;
            e_q.rep  <= '1;
        end else begin
            e_q <= e_d;
        end
    end

    for (genvar g = 0; g < N_SMF; g++) begin : g_out
        assign ebits_o[g] = sync_i ? e_q.rep[g] : async_ebit_i;
    end

    // R7
    rep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !tx_mf_tick_i) |=> $stable(e_q.rep));
    // R7
    entry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_i) |-> e_q.rep == '1 && e_q.pend == '1);
endmodule

// File: rtl/e1_crc4_sync_resp.sv
module e1_crc4_sync_resp
    import e1sr_pkg::*;
#(
    parameter int FRAMES_PER_MF = 16,
    parameter int SEARCH_MFS    = 4,
    parameter int N_SMF         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             basic_aligned_i,
    input  logic             align_lost_i,
    input  logic             mf_found_i,
    input  logic             frame_tick_i,
    input  logic             tx_mf_tick_i,
    input  logic [N_SMF-1:0] smf_checked_i,
    input  logic [N_SMF-1:0] smf_crc_bad_i,
    input  logic             async_ebit_i,
    output logic             search_restart_o,
    output logic             tx_a_bit_o,
    output logic [N_SMF-1:0] tx_ebits_o
);
    align_e state;

    e1sr_align #(
        .FRAMES_PER_MF(FRAMES_PER_MF),
        .SEARCH_MFS   (SEARCH_MFS)
    ) u_align (
        .clk            (clk),
        .rst_n          (rst_n),
        .basic_aligned_i(basic_aligned_i),
        .align_lost_i   (align_lost_i),
        .mf_found_i     (mf_found_i),
        .frame_tick_i   (frame_tick_i),
        .state_o        (state),
        .restart_o      (search_restart_o)
    );

    e1sr_rai u_rai (
        .clk            (clk),
        .rst_n          (rst_n),
        .basic_aligned_i(basic_aligned_i),
        .align_lost_i   (align_lost_i),
        .rai_o          (tx_a_bit_o)
    );

    e1sr_ebit #(.N_SMF(N_SMF)) u_ebit (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (state == ALIGN_MULTI),
        .tx_mf_tick_i (tx_mf_tick_i),
        .smf_checked_i(smf_checked_i),
        .smf_crc_bad_i(smf_crc_bad_i),
        .async_ebit_i (async_ebit_i),
        .ebits_o      (tx_ebits_o)
    );

    // R8
    async_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ALIGN_MULTI) |-> tx_ebits_o == {N_SMF{async_ebit_i}});
endmodule

// File: tb/sim_e1_crc4_sync_resp.sv
module sim_e1_crc4_sync_resp;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bfa = 0, lfa = 0, mff = 0, ft = 0, txt = 0, epol = 0;
    logic [1:0] chk = 0, bad = 0;
    logic restart, abit;
    logic [1:0] eb;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    e1_crc4_sync_resp u0 (
        .clk(clk), .rst_n(rst_n), .basic_aligned_i(bfa), .align_lost_i(lfa),
        .mf_found_i(mff), .frame_tick_i(ft), .tx_mf_tick_i(txt),
        .smf_checked_i(chk), .smf_crc_bad_i(bad), .async_ebit_i(epol),
        .search_restart_o(restart), .tx_a_bit_o(abit), .tx_ebits_o(eb)
    );

    // reference model written from the requirements
    int m_st, m_cnt;
    logic m_rst, m_rai;
    logic [1:0] m_pend, m_rep;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_rst <= 0; m_rai <= 1; m_pend <= 2'b11; m_rep <= 2'b11;
        end else begin
            m_rst <= 0;
            if (lfa) begin m_st <= 0; m_cnt <= 0; end
            else if (m_st == 0) begin if (bfa) begin m_st <= 1; m_cnt <= 0; end end
            else if (m_st == 1) begin
                if (mff) begin m_st <= 2; m_cnt <= 0; end
                else if (ft) begin
                    if (m_cnt == 63) begin m_rst <= 1; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end
            m_rai <= lfa ? 1'b1 : (bfa ? 1'b0 : m_rai);
            if (m_st != 2) begin m_pend <= 2'b11; m_rep <= 2'b11; end
            else begin
                logic [1:0] np;
                np = txt ? 2'b11 : m_pend;
                for (int k = 0; k < 2; k++) if (chk[k]) np[k] = ~bad[k];
                m_pend <= np;
                if (txt) m_rep <= m_pend;
            end
        end
    end

    function automatic logic [1:0] exp_eb();
        return (m_st == 2) ? m_rep : {2{epol}};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        mff = 0; ft = 0; txt = 0; chk = 0; bad = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seen;
        int dummy;
        dummy = $urandom(32'd1357);
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 restart", restart, 0);
        check("R1 abit", abit, 1);
        check("R8 async ebit pol0", eb, 2'b00);
        epol = 1; #1;
        check("R8 async ebit pol1", eb, 2'b11);
        rst_n = 1; tick();
        // frame ticks while unaligned do not count (R9)
        ft = 1; for (int i = 0; i < 40; i++) tick();
        ft = 0;
        // basic alignment clears RAI (R6)
        bfa = 1; tick();
        check("R6 rai clear", abit, 0);
        bfa = 0; tick();
        check("R6 rai hold", abit, 0);
        // loss sets RAI (R5)
        lfa = 1; tick();
        check("R5 rai set", abit, 1);
        lfa = 0; bfa = 1; tick();
        check("R6 rai clear again", abit, 0);
        // timeout: 63 ticks no restart, 64th gives pulse (R2)
        seen = 0; ft = 1;
        for (int i = 0; i < 63; i++) begin tick(); if (restart) seen++; end
        check("R2 no early restart", seen[7:0], 0);
        tick();
        check("R2 restart on 64th", restart, 1);
        ft = 0; tick();
        check("R2 single cycle", restart, 0);
        // counter cleared, next pulse after another 64 (R3)
        seen = 0; ft = 1;
        for (int i = 0; i < 63; i++) begin tick(); if (restart) seen++; end
        check("R3 no restart at 63", seen[7:0], 0);
        tick();
        check("R3 second restart", restart, 1);
        ft = 0;
        // some ticks then multiframe found (R4)
        ft = 1; for (int i = 0; i < 30; i++) tick();
        ft = 1; mff = 1; tick(); mff = 0;
        epol = 0; #1;
        check("R7 entry ebits", eb, 2'b11);
        seen = 0;
        for (int i = 0; i < 100; i++) begin tick(); if (restart) seen++; end
        check("R4 no restart in sync", seen[7:0], 0);
        ft = 0;
        // SMF I errored, SMF II clean -> 2'b10 after tx tick (R7)
        chk = 2'b11; bad = 2'b01; tick(); chk = 0; bad = 0;
        check("R7 pending not yet out", eb, 2'b11);
        txt = 1; tick(); txt = 0;
        check("R7 smf1 error", eb, 2'b10);
        chk = 2'b10; bad = 2'b10; tick(); chk = 0; bad = 0;
        txt = 1; tick(); txt = 0;
        check("R7 smf2 error", eb, 2'b01);
        txt = 1; tick(); txt = 0;
        check("R7 no check reports ok", eb, 2'b11);
        // CRC activity while unaligned ignored (R8), loss stops counting (R9)
        lfa = 1; bfa = 0; tick();
        check("R8 async after loss", eb, 2'b00);
        seen = 0; ft = 1; chk = 2'b11; bad = 2'b11; txt = 1;
        for (int i = 0; i < 70; i++) begin tick(); if (restart) seen++; if (eb != 2'b00) seen++; end
        check("R9 R8 unaligned quiet", seen[7:0], 0);
        idle_in(); lfa = 0; bfa = 1; tick();
        // R9 count restarts from zero on entry
        seen = 0; ft = 1;
        for (int i = 0; i < 63; i++) begin tick(); if (restart) seen++; end
        check("R9 fresh count", seen[7:0], 0);
        tick();
        check("R9 restart at 64 after entry", restart, 1);
        idle_in();
        // random phase against the model
        for (int i = 0; i < 20000; i++) begin
            ft   = ($urandom % 2) == 0;
            mff  = ($urandom % 250) == 0;
            txt  = ($urandom % 16) == 0;
            chk  = 2'($urandom);
            bad  = 2'($urandom);
            if (($urandom % 64) == 0) epol = ~epol;
            if (lfa) lfa = ($urandom % 8) != 0;
            else     lfa = ($urandom % 400) == 0;
            bfa  = ($urandom % 8) != 0;
            tick();
            check("R2 R3 restart", restart, m_rst);
            check("R5 R6 abit", abit, m_rai);
            check("R7 R8 ebits", eb, exp_eb());
        end
        finish_run();
    end
endmodule